// File: doc/BRIEF.md
# Two-Way Instruction Cache Debug Read Port

This block is a diagnostic window into a small two-way set-associative instruction cache model. It keeps, per way, an array of instruction words and an array of tag entries with their valid bits, plus one least-recently-used bit per set that both ways share. A fill port loads test contents. A debug request forms an effective address from two operands. It then copies either the addressed instruction word or a formatted tag word from an explicitly chosen way into a debug data register.

Requests from unprivileged code, and requests whose address has no translation while translation is on, return no data. Instead they raise a fault pulse. The register is not interlocked. Software must wait for the completion pulse, the stand-in for a synchronisation step, before it reads a value that is guaranteed to be new. Instruction fetch, refill from memory and real address translation are outside the block. A hit/miss input stands in for the translation lookup.

Top module: `icache_dbg_port`

## Requirements
- R1: The effective address is `rb_val_i` plus `ra_val_i`, with `ra_val_i` replaced by zero when `ra_idx_i` is 0. The word offset is taken from bits [4:2], the set index from bits [8:5] and the address tag from bits [31:9].
- R2: An accepted request with `sel_tag_i`=0 loads the addressed instruction word into `dbg_data_o`. The way comes from `sel_way_i` (0 = way A, 1 = way B).
- R3: An accepted request with `sel_tag_i`=1 loads a tag word for the way chosen by `sel_way_i`. In this word, bits [31:9] hold the stored tag, bit 4 holds the line valid bit (1 = valid), bit 0 holds the set's LRU bit, and all other bits are zero. In bit numbering that counts from the MSB, the valid bit is bit 27, bits 28-30 are zero and the LRU bit is bit 31.
- R4: Each set has one LRU bit, and it is shared by both ways. A value of 0 means way A is least recently used, and 1 means way B is. The same value appears in the tag word of either way.
- R5: A request with `user_mode_i`=1 gives a one-cycle `priv_fault_o` pulse on the next cycle. `done_o` stays low and `dbg_data_o` is unchanged.
- R6: A privileged request with `xlate_en_i`=1 and `xlate_hit_i`=0 gives a one-cycle `tlb_fault_o` pulse on the next cycle. `done_o` stays low and `dbg_data_o` is unchanged. When the request is also unprivileged, only `priv_fault_o` is raised.
- R7: An accepted request gives a one-cycle `done_o` pulse on the next cycle, and the new `dbg_data_o` value appears in that same cycle. Without a request, `done_o` and both fault outputs stay low and `dbg_data_o` holds its value. No other fault kind is ever signalled.
- R8: A fill is written at the clock edge that samples `fill_en_i`=1. The value of `fill_kind_i` selects the action: 2'b00 writes `fill_data_i` to the word at the `fill_addr_i` set and offset, 2'b01 writes the `fill_addr_i` tag and the valid bit `fill_bit_i`, 2'b10 writes the set's LRU bit from `fill_bit_i`, and 2'b11 does nothing. The way comes from `fill_way_i`. A request sampled at the same edge reads the contents from before the write.
- R9: Reset clears every valid bit, every LRU bit, every stored tag and `dbg_data_o`, and sets all pulse outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_en_i | input | 1 | Fill write strobe |
| fill_kind_i | input | 2 | Fill action: word, tag+valid, LRU, none |
| fill_way_i | input | 1 | Fill target way (0 = A) |
| fill_addr_i | input | 32 | Fill address supplying tag, set and offset |
| fill_data_i | input | 32 | Instruction word to store |
| fill_bit_i | input | 1 | Valid or LRU value to store |
| req_i | input | 1 | Debug read request |
| ra_idx_i | input | 5 | Index of the first operand register (0 forces the operand to zero) |
| ra_val_i | input | 32 | First operand value |
| rb_val_i | input | 32 | Second operand value |
| sel_tag_i | input | 1 | 0 = read instruction word, 1 = read tag word |
| sel_way_i | input | 1 | 0 = way A, 1 = way B |
| user_mode_i | input | 1 | Requester runs unprivileged |
| xlate_en_i | input | 1 | Address translation enabled |
| xlate_hit_i | input | 1 | A valid translation exists for the address |
| dbg_data_o | output | 32 | Debug data register |
| done_o | output | 1 | Completion pulse for an accepted request |
| priv_fault_o | output | 1 | Privilege fault pulse |
| tlb_fault_o | output | 1 | Translation miss fault pulse |

## Verification
Every cycle, the assertions check how a request resolves. They check which pulse follows it, that at most one pulse is ever high, that faulted or absent requests leave the debug register untouched, and that the reserved bits of a tag word read as zero. Only the bench's scenarios can show that the right word or tag comes back for a given operand sum, set and way. The same holds for the shared LRU bit showing in both ways, for the old contents being returned when a fill and a read share an edge, and for the reset contents. A behavioural model of the arrays is compared against the outputs on every clock.

// File: rtl/icdbg_pkg.sv
package icdbg_pkg;
  typedef enum logic [1:0] {
    FILL_WORD = 2'b00,
    FILL_TAG  = 2'b01,
    FILL_LRU  = 2'b10,
    FILL_NONE = 2'b11
  } fill_kind_e;

  localparam int unsigned NUM_WAYS = 2;
  localparam int unsigned BYTE_OFF_W = 2;
  localparam int unsigned VLD_POS = 4;
  localparam int unsigned LRU_POS = 0;
endpackage

// File: rtl/icdbg_ea.sv
module icdbg_ea #(
  parameter int unsigned AW     = 32,
  parameter int unsigned RIDX_W = 5,
  parameter int unsigned SET_W  = 4,
  parameter int unsigned OFF_W  = 3,
  localparam int unsigned TAG_W = AW - icdbg_pkg::BYTE_OFF_W - OFF_W - SET_W
) (
  input  logic [RIDX_W-1:0] ra_idx_i,
  input  logic [AW-1:0]     ra_val_i,
  input  logic [AW-1:0]     rb_val_i,
  output logic [SET_W-1:0]  set_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic [AW-1:0] base;
  logic [AW-1:0] ea;
  logic          unused_byte;

  assign base  = (ra_idx_i == '0) ? '0 : ra_val_i;
  assign ea    = base + rb_val_i;
  assign off_o = ea[icdbg_pkg::BYTE_OFF_W +: OFF_W];
  assign set_o = ea[icdbg_pkg::BYTE_OFF_W + OFF_W +: SET_W];
  assign tag_o = ea[AW-1 -: TAG_W];
  assign unused_byte = ^ea[icdbg_pkg::BYTE_OFF_W-1:0];
endmodule

// File: rtl/icdbg_store.sv
module icdbg_store
  import icdbg_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned SETS  = 16,
  parameter int unsigned WORDS = 8,
  parameter int unsigned TAG_W = 23,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned OFF_W = $clog2(WORDS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  fill_kind_e                    wr_kind_i,
  input  logic                          wr_way_i,
  input  logic [SET_W-1:0]              wr_set_i,
  input  logic [OFF_W-1:0]              wr_off_i,
  input  logic [TAG_W-1:0]              wr_tag_i,
  input  logic [DW-1:0]                 wr_word_i,
  input  logic                          wr_bit_i,
  input  logic [SET_W-1:0]              rd_set_i,
  input  logic [OFF_W-1:0]              rd_off_i,
  output logic [NUM_WAYS-1:0][DW-1:0]    rd_word_o,
  output logic [NUM_WAYS-1:0][TAG_W-1:0] rd_tag_o,
  output logic [NUM_WAYS-1:0]           rd_valid_o,
  output logic                          rd_lru_o
);
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lru_q <= '0;
    end else if (wr_en_i && wr_kind_i == FILL_LRU) begin
      lru_q[wr_set_i] <= wr_bit_i;
    end
  end

  assign rd_lru_o = lru_q[rd_set_i];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [DW-1:0]    word_mem [SETS*WORDS];
    logic [TAG_W-1:0] tag_q    [SETS];
    logic [SETS-1:0]  vld_q;
    logic             way_hit;

    assign way_hit = wr_en_i && (wr_way_i == 1'(w));

    always_ff @(posedge clk_i) begin
      if (way_hit && wr_kind_i == FILL_WORD) begin
        word_mem[{wr_set_i, wr_off_i}] <= wr_word_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
        vld_q <= '0;
      end else if (way_hit && wr_kind_i == FILL_TAG) begin
        tag_q[wr_set_i] <= wr_tag_i;
        vld_q[wr_set_i] <= wr_bit_i;
      end
    end

    assign rd_word_o[w]  = word_mem[{rd_set_i, rd_off_i}];
    assign rd_tag_o[w]   = tag_q[rd_set_i];
    assign rd_valid_o[w] = vld_q[rd_set_i];
  end
endmodule

// File: rtl/icdbg_fmt.sv
module icdbg_fmt
  import icdbg_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned TAG_W = 23
) (
  input  logic [NUM_WAYS-1:0][DW-1:0]    word_i,
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [NUM_WAYS-1:0]           valid_i,
  input  logic                          lru_i,
  input  logic                          sel_tag_i,
  input  logic                          sel_way_i,
  output logic [DW-1:0]                 value_o
);
  logic [DW-1:0] tag_word;

  always_comb begin
    tag_word                 = '0;
    tag_word[DW-1 -: TAG_W]  = tag_i[sel_way_i];
    tag_word[VLD_POS]        = valid_i[sel_way_i];
    tag_word[LRU_POS]        = lru_i;
    value_o = sel_tag_i ? tag_word : word_i[sel_way_i];
  end
endmodule

// File: rtl/icache_dbg_port.sv
module icache_dbg_port
  import icdbg_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned SETS   = 16,
  parameter int unsigned WORDS  = 8,
  parameter int unsigned RIDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_en_i,
  input  logic [1:0]        fill_kind_i,
  input  logic              fill_way_i,
  input  logic [AW-1:0]     fill_addr_i,
  input  logic [AW-1:0]     fill_data_i,
  input  logic              fill_bit_i,
  input  logic              req_i,
  input  logic [RIDX_W-1:0] ra_idx_i,
  input  logic [AW-1:0]     ra_val_i,
  input  logic [AW-1:0]     rb_val_i,
  input  logic              sel_tag_i,
  input  logic              sel_way_i,
  input  logic              user_mode_i,
  input  logic              xlate_en_i,
  input  logic              xlate_hit_i,
  output logic [AW-1:0]     dbg_data_o,
  output logic              done_o,
  output logic              priv_fault_o,
  output logic              tlb_fault_o
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned OFF_W = $clog2(WORDS);
  localparam int unsigned TAG_W = AW - BYTE_OFF_W - OFF_W - SET_W;

  logic [SET_W-1:0]              rd_set;
  logic [OFF_W-1:0]              rd_off;
  logic [TAG_W-1:0]              rd_addr_tag;
  logic [NUM_WAYS-1:0][AW-1:0]    rd_word;
  logic [NUM_WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [NUM_WAYS-1:0]           rd_valid;
  logic                          rd_lru;
  logic [AW-1:0]                 sel_value;
  logic                          priv_fault, tlb_fault, accept;
  logic                          unused_bits;

  icdbg_ea #(
    .AW(AW), .RIDX_W(RIDX_W), .SET_W(SET_W), .OFF_W(OFF_W)
  ) u_ea (
    .ra_idx_i (ra_idx_i),
    .ra_val_i (ra_val_i),
    .rb_val_i (rb_val_i),
    .set_o    (rd_set),
    .off_o    (rd_off),
    .tag_o    (rd_addr_tag)
  );

  icdbg_store #(
    .DW(AW), .SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (fill_en_i),
    .wr_kind_i  (fill_kind_e'(fill_kind_i)),
    .wr_way_i   (fill_way_i),
    .wr_set_i   (fill_addr_i[BYTE_OFF_W + OFF_W +: SET_W]),
    .wr_off_i   (fill_addr_i[BYTE_OFF_W +: OFF_W]),
    .wr_tag_i   (fill_addr_i[AW-1 -: TAG_W]),
    .wr_word_i  (fill_data_i),
    .wr_bit_i   (fill_bit_i),
    .rd_set_i   (rd_set),
    .rd_off_i   (rd_off),
    .rd_word_o  (rd_word),
    .rd_tag_o   (rd_tag),
    .rd_valid_o (rd_valid),
    .rd_lru_o   (rd_lru)
  );

  icdbg_fmt #(
    .DW(AW), .TAG_W(TAG_W)
  ) u_fmt (
    .word_i    (rd_word),
    .tag_i     (rd_tag),
    .valid_i   (rd_valid),
    .lru_i     (rd_lru),
    .sel_tag_i (sel_tag_i),
    .sel_way_i (sel_way_i),
    .value_o   (sel_value)
  );

  // privilege check outranks translation check
  assign priv_fault = req_i && user_mode_i;
  assign tlb_fault  = req_i && !user_mode_i && xlate_en_i && !xlate_hit_i;
  assign accept     = req_i && !user_mode_i && !(xlate_en_i && !xlate_hit_i);

  // the address tag only feeds the translation lookup, which lives outside
  assign unused_bits = ^{rd_addr_tag, fill_addr_i[BYTE_OFF_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbg_data_o   <= '0;
      done_o       <= 1'b0;
      priv_fault_o <= 1'b0;
      tlb_fault_o  <= 1'b0;
    end else begin
      done_o       <= accept;
      priv_fault_o <= priv_fault;
      tlb_fault_o  <= tlb_fault;
      if (accept) dbg_data_o <= sel_value;
    end
  end
endmodule

// File: rtl/icache_dbg_port_chk.sv
module icache_dbg_port_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          sel_tag_i,
  input logic          user_mode_i,
  input logic          xlate_en_i,
  input logic          xlate_hit_i,
  input logic [DW-1:0] dbg_data_o,
  input logic          done_o,
  input logic          priv_fault_o,
  input logic          tlb_fault_o
);
  p_priv_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && user_mode_i |=> priv_fault_o && !done_o && $stable(dbg_data_o));

  p_tlb_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !user_mode_i && xlate_en_i && !xlate_hit_i
      |=> tlb_fault_o && !priv_fault_o && !done_o && $stable(dbg_data_o));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !user_mode_i && !(xlate_en_i && !xlate_hit_i)
      |=> done_o && !priv_fault_o && !tlb_fault_o);

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !done_o && !priv_fault_o && !tlb_fault_o && $stable(dbg_data_o));

  p_one_outcome_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, priv_fault_o, tlb_fault_o}));

  p_tag_reserved_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && sel_tag_i && !user_mode_i && !(xlate_en_i && !xlate_hit_i)
      |=> dbg_data_o[3:1] == 3'b000);
endmodule

bind icache_dbg_port icache_dbg_port_chk #(.DW(AW)) u_chk (.*);

// File: tb/icache_dbg_port_bench.sv
module icache_dbg_port_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fill_en_i = 1'b0;
  logic [1:0]  fill_kind_i = 2'b11;
  logic        fill_way_i = 1'b0;
  logic [31:0] fill_addr_i = '0;
  logic [31:0] fill_data_i = '0;
  logic        fill_bit_i = 1'b0;
  logic        req_i = 1'b0;
  logic [4:0]  ra_idx_i = '0;
  logic [31:0] ra_val_i = '0;
  logic [31:0] rb_val_i = '0;
  logic        sel_tag_i = 1'b0;
  logic        sel_way_i = 1'b0;
  logic        user_mode_i = 1'b0;
  logic        xlate_en_i = 1'b0;
  logic        xlate_hit_i = 1'b0;
  logic [31:0] dbg_data_o;
  logic        done_o, priv_fault_o, tlb_fault_o;

  icache_dbg_port u_icache_dbg_port (.*);

  always #5 clk_i = ~clk_i;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_tag = "R9";

  // behavioural reference model
  logic [31:0] m_data [2][16][8];
  logic [22:0] m_tag  [2][16];
  logic        m_vld  [2][16];
  logic        m_lru  [16];
  logic [31:0] e_dbg;
  logic        e_done, e_priv, e_tlb;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 16; s++) begin
          m_tag[w][s] = '0;
          m_vld[w][s] = 1'b0;
        end
      for (int s = 0; s < 16; s++) m_lru[s] = 1'b0;
      e_dbg = '0; e_done = 0; e_priv = 0; e_tlb = 0;
    end else begin
      e_done = 0; e_priv = 0; e_tlb = 0;
      if (req_i) begin
        if (user_mode_i) e_priv = 1;
        else if (xlate_en_i && !xlate_hit_i) e_tlb = 1;
        else begin
          logic [31:0] ea;
          int s, o, w;
          ea = ((ra_idx_i == 0) ? 32'd0 : ra_val_i) + rb_val_i;
          s = int'(ea[8:5]); o = int'(ea[4:2]); w = int'(sel_way_i);
          if (!sel_tag_i) e_dbg = m_data[w][s][o];
          else e_dbg = {m_tag[w][s], 4'b0000, m_vld[w][s], 3'b000, m_lru[s]};
          e_done = 1;
        end
      end
      if (fill_en_i) begin
        int s, o, w;
        s = int'(fill_addr_i[8:5]); o = int'(fill_addr_i[4:2]); w = int'(fill_way_i);
        case (fill_kind_i)
          2'b00: m_data[w][s][o] = fill_data_i;
          2'b01: begin m_tag[w][s] = fill_addr_i[31:9]; m_vld[w][s] = fill_bit_i; end
          2'b10: m_lru[s] = fill_bit_i;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk_i) begin
    #1;
    if (rst_ni) begin
      check(dbg_data_o === e_dbg, cur_tag, "dbg_data", dbg_data_o, e_dbg);
      check({done_o, priv_fault_o, tlb_fault_o} === {e_done, e_priv, e_tlb}, cur_tag,
            "pulses", {29'd0, done_o, priv_fault_o, tlb_fault_o}, {29'd0, e_done, e_priv, e_tlb});
    end
  end

  function automatic logic [31:0] pat(int w, int s, int o);
    return 32'hC000_0000 ^ (w << 20) ^ (s << 8) ^ o ^ (o << 24);
  endfunction

  function automatic logic [31:0] mk_addr(logic [22:0] t, int s, int o);
    return {t, 4'(s), 3'(o), 2'b00};
  endfunction

  task automatic do_fill(input logic [1:0] kind, input logic w, input logic [31:0] a,
                         input logic [31:0] d, input logic b);
    fill_en_i = 1; fill_kind_i = kind; fill_way_i = w; fill_addr_i = a;
    fill_data_i = d; fill_bit_i = b;
    @(posedge clk_i); #2;
    fill_en_i = 0; fill_kind_i = 2'b11;
  endtask

  task automatic do_req(input logic [4:0] idx, input logic [31:0] a, input logic [31:0] b,
                        input logic t, input logic w, input logic u, input logic xe,
                        input logic xh, input string tag);
    cur_tag = tag;
    req_i = 1; ra_idx_i = idx; ra_val_i = a; rb_val_i = b;
    sel_tag_i = t; sel_way_i = w; user_mode_i = u; xlate_en_i = xe; xlate_hit_i = xh;
    @(posedge clk_i); #2;
    req_i = 0; user_mode_i = 0; xlate_en_i = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] a3;
    logic [31:0] held;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1;
    @(posedge clk_i); #2;
    // R9: reset values
    check(dbg_data_o == 0, "R9", "dbg after reset", dbg_data_o, 0);
    check(!done_o && !priv_fault_o && !tlb_fault_o, "R9", "pulses after reset",
          {29'd0, done_o, priv_fault_o, tlb_fault_o}, 0);
    do_req(5'd0, 0, mk_addr(23'h1, 3, 0), 1, 0, 0, 0, 0, "R9");
    check(dbg_data_o == 0, "R9", "tag word of unfilled line", dbg_data_o, 0);
    do_req(5'd0, 0, mk_addr(23'h1, 3, 0), 1, 1, 0, 0, 0, "R9");
    check(dbg_data_o == 0, "R9", "tag word way B after reset", dbg_data_o, 0);

    // R8: prefill all words of both ways
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 16; s++)
        for (int o = 0; o < 8; o++)
          do_fill(2'b00, 1'(w), mk_addr(23'h0, s, o), pat(w, s, o), 0);
    do_fill(2'b01, 0, mk_addr(23'h1234, 3, 0), 0, 1);
    do_fill(2'b01, 1, mk_addr(23'h0ABC, 3, 0), 0, 1);
    do_fill(2'b10, 0, mk_addr(23'h0, 3, 0), 0, 1);

    // R1 / R2: operand forms and way selection
    a3 = mk_addr(23'h1234, 3, 5);
    do_req(5'd0, 32'hFFFF_0000, a3, 0, 0, 0, 0, 0, "R1");
    check(dbg_data_o == pat(0, 3, 5), "R1", "index 0 ignores ra", dbg_data_o, pat(0, 3, 5));
    check(done_o, "R7", "done after accept", {31'd0, done_o}, 1);
    do_req(5'd7, 32'h0000_0100, a3 - 32'h100, 0, 1, 0, 0, 0, "R1");
    check(dbg_data_o == pat(1, 3, 5), "R1", "sum of operands", dbg_data_o, pat(1, 3, 5));
    do_req(5'd2, 32'h0000_0040, mk_addr(23'h7, 9, 1), 0, 0, 0, 0, 0, "R2");
    check(dbg_data_o == pat(0, 11, 1), "R2", "carry into set field", dbg_data_o, pat(0, 11, 1));

    // R3 / R4: tag word layout and shared LRU
    do_req(5'd0, 0, a3, 1, 0, 0, 0, 0, "R3");
    check(dbg_data_o == {23'h1234, 4'b0, 1'b1, 3'b0, 1'b1}, "R3", "tag word way A",
          dbg_data_o, {23'h1234, 4'b0, 1'b1, 3'b0, 1'b1});
    do_req(5'd0, 0, a3, 1, 1, 0, 0, 0, "R4");
    check(dbg_data_o == {23'h0ABC, 4'b0, 1'b1, 3'b0, 1'b1}, "R4", "LRU shared in way B",
          dbg_data_o, {23'h0ABC, 4'b0, 1'b1, 3'b0, 1'b1});
    do_fill(2'b10, 1, mk_addr(23'h0, 3, 0), 0, 0);
    do_req(5'd0, 0, a3, 1, 0, 0, 0, 0, "R4");
    check(dbg_data_o[0] == 1'b0, "R4", "LRU cleared way A", {31'd0, dbg_data_o[0]}, 0);
    do_fill(2'b01, 0, mk_addr(23'h0055, 3, 0), 0, 0);
    do_req(5'd0, 0, a3, 1, 0, 0, 0, 0, "R3");
    check(dbg_data_o == {23'h0055, 9'b0}, "R3", "invalid line tag word",
          dbg_data_o, {23'h0055, 9'b0});

    // R5 / R6: faults keep the register
    held = dbg_data_o;
    do_req(5'd0, 0, a3, 0, 0, 1, 0, 0, "R5");
    check(priv_fault_o && !done_o && dbg_data_o == held, "R5", "user mode fault", dbg_data_o, held);
    do_req(5'd0, 0, a3, 0, 0, 0, 1, 0, "R6");
    check(tlb_fault_o && !done_o && dbg_data_o == held, "R6", "translation miss", dbg_data_o, held);
    do_req(5'd0, 0, a3, 0, 0, 1, 1, 0, "R6");
    check(priv_fault_o && !tlb_fault_o, "R6", "privilege outranks miss",
          {30'd0, priv_fault_o, tlb_fault_o}, 32'd2);
    do_req(5'd0, 0, a3, 0, 1, 0, 1, 1, "R6");
    check(done_o && dbg_data_o == pat(1, 3, 5), "R6", "translation hit accepted",
          dbg_data_o, pat(1, 3, 5));

    // R7: idle holds
    cur_tag = "R7";
    @(posedge clk_i); #2;
    check(!done_o && dbg_data_o == pat(1, 3, 5), "R7", "idle after done", dbg_data_o, pat(1, 3, 5));

    // R8: same-edge fill and read
    cur_tag = "R8";
    fill_en_i = 1; fill_kind_i = 2'b00; fill_way_i = 0;
    fill_addr_i = mk_addr(23'h0, 6, 2); fill_data_i = 32'hDEAD_BEEF;
    req_i = 1; ra_idx_i = 0; rb_val_i = mk_addr(23'h0, 6, 2); sel_tag_i = 0; sel_way_i = 0;
    @(posedge clk_i); #2;
    fill_en_i = 0; fill_kind_i = 2'b11; req_i = 0;
    check(dbg_data_o == pat(0, 6, 2), "R8", "read sees pre-fill word", dbg_data_o, pat(0, 6, 2));
    do_req(5'd0, 0, mk_addr(23'h0, 6, 2), 0, 0, 0, 0, 0, "R8");
    check(dbg_data_o == 32'hDEAD_BEEF, "R8", "read sees new word", dbg_data_o, 32'hDEAD_BEEF);
    do_fill(2'b11, 0, mk_addr(23'h0, 6, 2), 32'h1111_1111, 0);
    do_req(5'd0, 0, mk_addr(23'h0, 6, 2), 0, 0, 0, 0, 0, "R8");
    check(dbg_data_o == 32'hDEAD_BEEF, "R8", "no-op fill kind", dbg_data_o, 32'hDEAD_BEEF);

    // mixed traffic checked by the model each cycle
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 0)
        do_fill(r[5:4], r[6], $urandom, $urandom, r[7]);
      else if (r[3:0] == 1) begin
        cur_tag = "R7";
        @(posedge clk_i); #2;
      end else
        do_req(5'(r[12:8]), $urandom, $urandom, r[13], r[14], r[15] & r[16],
               r[17], r[18] | r[19], r[13] ? "R3" : "R2");
    end

    repeat (2) @(posedge clk_i);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule